// File: doc/BRIEF.md
# Synchronized Four-Group Center-Aligned PWM

This block drives four PWM outputs. Each output comes from its own group, and each group has a triangle counter. The counter climbs from zero to a programmed period value and then falls back. The output is a pulse centred on the point where the counter is at zero. Software reaches the block through one write port. Each group has a period register, two duty registers and a mode register. A global control word holds two bits per group: an output-enable bit and a counter-start bit.

In single-update mode the first duty value sets the on-time in both halves of the period, so the pulse width moves in steps of two clocks. In double-update mode the rising half uses the first duty value and the falling half uses the second, so the pulse width moves in steps of one clock. Written values wait in shadow registers. They reach the active set at the end of a period. In double-update mode the duty values are also taken at the turning point. Counters can be started with their outputs still off. Later, the outputs can be switched on without disturbing the counters' phase. Groups enabled by the same control write start on the same clock.

Top module: `sync_pwm_top`

## Requirements
- R1: While rst_n is low, every bit of pwm_out is 0, and after reset every group is disabled.
- R2: With active period P ≥ 1, a running counter visits 0,1,…,P−1 while rising and P,P−1,…,1 while falling, so one period lasts 2P clocks.
- R3: A running group with its output enabled drives 1 when, in the rising half, count < first duty, or, in the falling half, count ≤ duty of that half. Otherwise it drives 0. Each duty value D < P therefore gives D high clocks per half.
- R4: With the mode register bit 0 at 0 (single-update), the second duty register has no effect on the output.
- R5: With mode bit 0 at 1 (double-update), the falling half uses the second duty value.
- R6: Period, duties and mode written to a group take effect only when the counter wraps from 1 to 0 or while the group is idle. In double-update mode the duties also take effect at the turning point, where the count goes from P−1 to P.
- R7: A group whose output-enable and counter-start bits are both 0 holds its output at 0 and its counter at 0 in the rising direction.
- R8: The counter-start bit alone runs the counter with the output held at 0. When the output-enable bit is set later, the output follows the counter phase that is already running.
- R9: Groups enabled by one control write (address 0: bits 3:0 output enable, bits 7:4 counter start, bit g for group g) begin counting on the same clock.
- R10: A duty value of 0 gives a constant 0. A duty value ≥ P gives a constant 1.
- R11: An active period of 0 holds the counter at 0 in the rising direction.

Register addresses: group g uses address 1+4g for the period, 2+4g for the first duty, 3+4g for the second duty, and 4+4g for the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| pwm_out | output | 4 | One PWM output per group |

## Verification
A counter in the wrong state, or turning at the wrong time, moves the pulse edges. The error shows on pwm_out within one half-period, because every edge is a compare against the count. A shadow value loaded at the wrong moment changes a pulse width in the half where it is used, and that can be seen within one period. Wrong start alignment between groups shows immediately as edges that differ between groups with equal settings.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;
  localparam int REG_CTRL   = 0;
  localparam int GRP_BASE   = 1;
  localparam int GRP_STRIDE = 4;
  localparam int OFS_PER    = 0;
  localparam int OFS_DUTY_A = 1;
  localparam int OFS_DUTY_B = 2;
  localparam int OFS_MODE   = 3;
endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import sync_pwm_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [GROUPS-1:0]            oen,
  output logic [GROUPS-1:0]            sen,
  output logic [GROUPS-1:0][CNT_W-1:0] sh_per,
  output logic [GROUPS-1:0][CNT_W-1:0] sh_da,
  output logic [GROUPS-1:0][CNT_W-1:0] sh_db,
  output logic [GROUPS-1:0]            sh_dbl
);
  localparam int CTRL_ADDR = REG_CTRL;

  logic ctrl_hit;
  assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR[ADDR_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oen <= '0;
      sen <= '0;
    end else if (ctrl_hit) begin
      oen <= wr_data[GROUPS-1:0];
      sen <= wr_data[2*GROUPS-1:GROUPS];
    end
  end

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_grp
    localparam int A_PER  = GRP_BASE + gi*GRP_STRIDE + OFS_PER;
    localparam int A_DA   = GRP_BASE + gi*GRP_STRIDE + OFS_DUTY_A;
    localparam int A_DB   = GRP_BASE + gi*GRP_STRIDE + OFS_DUTY_B;
    localparam int A_MODE = GRP_BASE + gi*GRP_STRIDE + OFS_MODE;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_per[gi] <= '0;
        sh_da[gi]  <= '0;
        sh_db[gi]  <= '0;
        sh_dbl[gi] <= 1'b0;
      end else if (wr_en) begin
        if (wr_addr == A_PER[ADDR_W-1:0])  sh_per[gi] <= wr_data[CNT_W-1:0];
        if (wr_addr == A_DA[ADDR_W-1:0])   sh_da[gi]  <= wr_data[CNT_W-1:0];
        if (wr_addr == A_DB[ADDR_W-1:0])   sh_db[gi]  <= wr_data[CNT_W-1:0];
        if (wr_addr == A_MODE[ADDR_W-1:0]) sh_dbl[gi] <= wr_data[0];
      end
    end
  end
endmodule

// File: rtl/pwm_group_core.sv
module pwm_group_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oen,
  input  logic             sen,
  input  logic [CNT_W-1:0] sh_per,
  input  logic [CNT_W-1:0] sh_da,
  input  logic [CNT_W-1:0] sh_db,
  input  logic             sh_dbl,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic level_of(input logic [CNT_W-1:0] c, input logic rising,
                                    input logic [CNT_W-1:0] d);
    return rising ? (c < d) : (c <= d);
  endfunction

  logic [CNT_W-1:0] cnt_q, per_a, da_a, db_a;
  logic             up_q, dbl_a;

  logic             run, wrap_evt, turn_evt, load_full, load_mid;
  logic [CNT_W-1:0] cur_duty;

  assign run       = oen | sen;
  assign wrap_evt  = run && (per_a != '0) && !up_q && (cnt_q == ONE);
  assign turn_evt  = run && (per_a != '0) && up_q && (cnt_q == per_a - ONE);
  assign load_full = !run || (per_a == '0) || wrap_evt;
  assign load_mid  = turn_evt && dbl_a;
  assign cur_duty  = (up_q || !dbl_a) ? da_a : db_a;
  assign pwm_o     = oen && level_of(cnt_q, up_q, cur_duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!run || per_a == '0) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (turn_evt) begin
      cnt_q <= per_a;
      up_q  <= 1'b0;
    end else if (wrap_evt) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      cnt_q <= cnt_q + ONE;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_a <= '0;
      da_a  <= '0;
      db_a  <= '0;
      dbl_a <= 1'b0;
    end else if (load_full) begin
      per_a <= sh_per;
      da_a  <= sh_da;
      db_a  <= sh_db;
      dbl_a <= sh_dbl;
    end else if (load_mid) begin
      da_a  <= sh_da;
      db_a  <= sh_db;
    end
  end

  a_r7_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !oen |-> !pwm_o);
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && up_q));
  a_r2_within_period: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_a);
  a_r2_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
    turn_evt |=> !up_q);
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == '0 && up_q));
  a_r10_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_duty == '0 && !up_q) |-> !pwm_o);
endmodule

// File: rtl/sync_pwm_top.sv
module sync_pwm_top #(
  parameter int GROUPS = 4,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [GROUPS-1:0] pwm_out
);
  logic [GROUPS-1:0]            oen, sen, sh_dbl;
  logic [GROUPS-1:0][CNT_W-1:0] sh_per, sh_da, sh_db;

  pwm_ctrl_regs #(.GROUPS(GROUPS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .oen(oen), .sen(sen), .sh_per(sh_per), .sh_da(sh_da), .sh_db(sh_db), .sh_dbl(sh_dbl)
  );

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_core
    pwm_group_core #(.CNT_W(CNT_W)) core_i (
      .clk(clk), .rst_n(rst_n), .oen(oen[gi]), .sen(sen[gi]),
      .sh_per(sh_per[gi]), .sh_da(sh_da[gi]), .sh_db(sh_db[gi]), .sh_dbl(sh_dbl[gi]),
      .pwm_o(pwm_out[gi])
    );
  end

  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> pwm_out == '0);
endmodule

// File: tb/sync_pwm_top_tb_top.sv
module sync_pwm_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit checking = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt[4], a_per[4], a_da[4], a_db[4], s_per[4], s_da[4], s_db[4];
  bit m_up[4], a_dbl[4], s_dbl[4], m_oen[4], m_sen[4];

  sync_pwm_top dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                      .wr_data(wr_data), .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 4; g++) begin
        m_cnt[g] = 0; m_up[g] = 1; a_per[g] = 0; a_da[g] = 0; a_db[g] = 0; a_dbl[g] = 0;
        s_per[g] = 0; s_da[g] = 0; s_db[g] = 0; s_dbl[g] = 0; m_oen[g] = 0; m_sen[g] = 0;
      end
    end else begin
      for (int g = 0; g < 4; g++) begin
        if (!(m_oen[g] || m_sen[g]) || a_per[g] == 0) begin
          m_cnt[g] = 0; m_up[g] = 1;
          a_per[g] = s_per[g]; a_da[g] = s_da[g]; a_db[g] = s_db[g]; a_dbl[g] = s_dbl[g];
        end else if (m_up[g]) begin
          if (m_cnt[g] == a_per[g] - 1) begin
            if (a_dbl[g]) begin a_da[g] = s_da[g]; a_db[g] = s_db[g]; end
            m_cnt[g] = a_per[g]; m_up[g] = 0;
          end else m_cnt[g] = m_cnt[g] + 1;
        end else begin
          if (m_cnt[g] == 1) begin
            m_cnt[g] = 0; m_up[g] = 1;
            a_per[g] = s_per[g]; a_da[g] = s_da[g]; a_db[g] = s_db[g]; a_dbl[g] = s_dbl[g];
          end else m_cnt[g] = m_cnt[g] - 1;
        end
      end
      if (wr_en) begin
        if (wr_addr == 0) begin
          for (int g = 0; g < 4; g++) begin
            m_oen[g] = wr_data[g]; m_sen[g] = wr_data[4+g];
          end
        end else begin
          int g, o;
          g = (int'(wr_addr) - 1) / 4;
          o = (int'(wr_addr) - 1) % 4;
          if (g < 4) begin
            case (o)
              0: s_per[g] = int'(wr_data[7:0]);
              1: s_da[g]  = int'(wr_data[7:0]);
              2: s_db[g]  = int'(wr_data[7:0]);
              default: s_dbl[g] = wr_data[0];
            endcase
          end
        end
      end
    end
  end

  function automatic logic [3:0] expected_out();
    logic [3:0] e;
    for (int g = 0; g < 4; g++) begin
      int d;
      d = (m_up[g] || !a_dbl[g]) ? a_da[g] : a_db[g];
      e[g] = m_oen[g] && (m_up[g] ? (m_cnt[g] < d) : (m_cnt[g] <= d));
    end
    return e;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (checking) begin
      logic [3:0] exp_v;
      exp_v = rst_n ? expected_out() : 4'b0000;
      checks++;
      if (pwm_out !== exp_v) begin
        errors++;
        $display("FAIL %s cycle %0d: pwm_out=%b expected=%b", cur_req, cycles, pwm_out, exp_v);
      end
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 16'(data);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic grp(input int g, input int per, input int da, input int db, input int dbl);
    wr(1 + 4*g + 0, per);
    wr(1 + 4*g + 1, da);
    wr(1 + 4*g + 2, db);
    wr(1 + 4*g + 3, dbl);
  endtask

  initial begin
    // R1: outputs low while reset held
    @(posedge clk); #1; checking = 1;
    run(3);
    #1 rst_n = 1'b1;
    cur_req = "R1 R7";
    run(3);
    // R3 R5 R10: program while idle
    grp(0, 6, 2, 5, 0);
    grp(1, 5, 1, 4, 1);
    grp(2, 4, 0, 0, 0);
    grp(3, 3, 9, 9, 0);
    // R9 R2: enable all in one write
    cur_req = "R2 R3 R5 R9 R10";
    wr(0, 16'h000F);
    run(40);
    // R6: shadow updates at boundaries
    cur_req = "R6";
    wr(2, 5);
    run(25);
    wr(6, 3);
    run(25);
    // R4: single update ignores second duty
    cur_req = "R4";
    wr(8, 0);
    wr(7, 0);
    run(30);
    // R7: all disabled
    cur_req = "R7";
    wr(0, 16'h0000);
    run(10);
    // R8: counters start with outputs off, outputs enabled later
    cur_req = "R8";
    wr(0, 16'h00F0);
    run(13);
    wr(0, 16'h00FF);
    run(30);
    // R11: period zero
    cur_req = "R11";
    wr(9, 0);
    wr(10, 1);
    run(20);
    wr(10, 0);
    run(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule